// File: doc/BRIEF.md
# Streaming Top-Two Maximum Tracker

This block watches a stream of unsigned samples, at most one per clock, qualified by a valid strobe. For each run it keeps the largest and the second-largest value seen since the last clear (or reset), using two holding slots and two comparators that both act in the same cycle. A run is a fixed number of accepted samples. When the last sample of a run has been absorbed, both results are already on the outputs and a single-cycle done pulse marks the moment.

A new largest value pushes the previous largest down into the second slot. Because of this, the second result stays correct even when the largest value comes early in the run. Each slot carries its own "filled" flag instead of a sentinel value, so zero is ordinary data. A sample equal to the current largest counts as a new largest. A repeated maximum is therefore reported in both slots.

Samples that arrive after the run has completed are dropped. The results hold until a clear pulse starts a new run. Clear wins over a valid sample in the same cycle.

Top module: `top2_tracker`

## Requirements
- R1: After reset, both slot-filled outputs and done_o are 0, and a run of RUN_LEN accepted samples starts from empty.
- R2: An accepted sample that is greater than or equal to the highest value, or arrives while the highest slot is empty, becomes the highest value at the next edge. The previous highest (value and filled flag) moves into the second slot. A repeated maximum therefore appears in both slots.
- R3: An accepted sample below the highest that is strictly greater than the second value, or arrives while the second slot is empty, replaces the second value. The highest slot is unchanged.
- R4: An accepted sample below the highest and not above the filled second value changes neither slot.
- R5: When the largest value arrives before all others, the second slot still ends with the largest of the remaining samples.
- R6: The value 0 is valid data. A run of zeros reports both slots filled with value 0.
- R7: done_o is high for exactly one cycle. It appears at the edge that absorbs the RUN_LEN-th accepted sample, and the final results are present in that same cycle.
- R8: After RUN_LEN samples have been accepted, further valid samples are ignored. The outputs stay unchanged and done_o stays low until a clear.
- R9: clear_i empties both slots at the next edge. A valid sample in the same cycle as clear_i is dropped.
- R10: Cycles with valid_i low change neither the slots nor the sample count.
- R11: A clear in the middle of a run restarts the count. done_o then needs RUN_LEN further accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new run; empties both slots |
| valid_i | input | 1 | sample_i carries a sample this cycle |
| sample_i | input | DATA_W | Unsigned sample |
| first_vld_o | output | 1 | Highest slot holds a value |
| first_o | output | DATA_W | Highest value of the run so far |
| second_vld_o | output | 1 | Second slot holds a value |
| second_o | output | DATA_W | Second-highest value of the run so far |
| done_o | output | 1 | One-cycle pulse when the run completes |

## Verification
A broken comparator or a failed demotion shows at the ports one edge after the offending sample: the pair of outputs no longer matches the two largest values of the history. The bench therefore compares both slots after every single sample, not only at the end of a run. A wrong sample count appears as a done pulse that comes early, comes late or repeats, or as a sample accepted after completion. The bench watches done_o on every cycle, including cycles after the run has finished and cycles following a clear.

// File: rtl/top2_pkg.sv
package top2_pkg;
    // Where an accepted sample lands in the pair of holding slots.
    typedef enum logic [1:0] {
        PLACE_NONE   = 2'd0,
        PLACE_SECOND = 2'd1,
        PLACE_FIRST  = 2'd2
    } place_e;
endpackage

// File: rtl/top2_rank_cmp.sv
module top2_rank_cmp
    import top2_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              first_full_i,
    input  logic [DATA_W-1:0] first_val_i,
    input  logic              second_full_i,
    input  logic [DATA_W-1:0] second_val_i,
    input  logic [DATA_W-1:0] sample_i,
    output place_e            place_o
);
    logic beats_first;
    logic beats_second;

    // Both comparisons happen in parallel; ties with the leader win.
    always_comb begin
        beats_first  = !first_full_i  || (sample_i >= first_val_i);
        beats_second = !second_full_i || (sample_i >  second_val_i);
        if (beats_first) begin
            place_o = PLACE_FIRST;
        end else if (beats_second) begin
            place_o = PLACE_SECOND;
        end else begin
            place_o = PLACE_NONE;
        end
    end

    always_comb begin
        assert_place_first_on_empty_R2: assert (first_full_i || place_o == PLACE_FIRST);
    end
endmodule

// File: rtl/top2_run_counter.sv
module top2_run_counter #(
    parameter int RUN_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic valid_i,
    output logic accept_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       complete;

    always_comb begin
        complete = (st_q.count == CNT_FULL);
        accept_o = valid_i && !clear_i && !complete;
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d.count = '0;
        end else if (accept_o) begin
            st_d.count = st_q.count + 1'b1;
            st_d.done  = (st_q.count == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_FULL);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    assert_clear_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.count == '0 && !st_q.done));
    assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clear_i) |=> $stable(st_q.count));
endmodule

// File: rtl/top2_slots.sv
module top2_slots
    import top2_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              accept_i,
    input  place_e            place_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              first_full_o,
    output logic [DATA_W-1:0] first_val_o,
    output logic              second_full_o,
    output logic [DATA_W-1:0] second_val_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] val;
    } slot_t;

    typedef struct packed {
        slot_t first;
        slot_t second;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (clear_i) begin
            pair_d = '0;
        end else if (accept_i) begin
            case (place_i)
                PLACE_FIRST: begin
                    pair_d.second = pair_q.first;
                    pair_d.first  = '{full: 1'b1, val: sample_i};
                end
                PLACE_SECOND: begin
                    pair_d.second = '{full: 1'b1, val: sample_i};
                end
                default: begin
                    pair_d = pair_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign first_full_o  = pair_q.first.full;
    assign first_val_o   = pair_q.first.val;
    assign second_full_o = pair_q.second.full;
    assign second_val_o  = pair_q.second.val;

    assert_order_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_q.first.full && pair_q.second.full) |-> (pair_q.second.val <= pair_q.first.val));
    assert_second_needs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_q.second.full |-> pair_q.first.full);
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!pair_q.first.full && !pair_q.second.full));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clear_i) |=> $stable(pair_q));
    assert_demote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !clear_i && place_i == PLACE_FIRST && pair_q.first.full)
        |=> (pair_q.second.full && pair_q.second.val == $past(pair_q.first.val)));
    assert_leader_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !clear_i && place_i == PLACE_SECOND) |=> $stable(pair_q.first));
endmodule

// File: rtl/top2_tracker.sv
module top2_tracker
    import top2_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              first_vld_o,
    output logic [DATA_W-1:0] first_o,
    output logic              second_vld_o,
    output logic [DATA_W-1:0] second_o,
    output logic              done_o
);
    logic   accept;
    place_e place;

    top2_run_counter #(.RUN_LEN(RUN_LEN)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .valid_i  (valid_i),
        .accept_o (accept),
        .done_o   (done_o)
    );

    top2_rank_cmp #(.DATA_W(DATA_W)) u_cmp (
        .first_full_i  (first_vld_o),
        .first_val_i   (first_o),
        .second_full_i (second_vld_o),
        .second_val_i  (second_o),
        .sample_i      (sample_i),
        .place_o       (place)
    );

    top2_slots #(.DATA_W(DATA_W)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .accept_i      (accept),
        .place_i       (place),
        .sample_i      (sample_i),
        .first_full_o  (first_vld_o),
        .first_val_o   (first_o),
        .second_full_o (second_vld_o),
        .second_val_o  (second_o)
    );

    assert_done_has_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> first_vld_o);
    assert_frozen_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> ($stable(first_o) && $stable(second_o) && !done_o));
endmodule

// File: tb/top2_tracker_test.sv
module top2_tracker_test;
    localparam int DW  = 8;
    localparam int RUN = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          valid_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          first_vld_o, second_vld_o, done_o;
    logic [DW-1:0] first_o, second_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int hist[$];
    int nacc = 0;

    always #2 clk = ~clk;

    top2_tracker #(.DATA_W(DW), .RUN_LEN(RUN)) uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .valid_i(valid_i),
        .sample_i(sample_i), .first_vld_o(first_vld_o), .first_o(first_o),
        .second_vld_o(second_vld_o), .second_o(second_o), .done_o(done_o)
    );

    task automatic expected(output logic v1, output int a1, output logic v2, output int a2);
        int bi = -1;
        v1 = 0; v2 = 0; a1 = 0; a2 = 0;
        foreach (hist[i]) if (bi < 0 || hist[i] > hist[bi]) bi = i;
        if (bi >= 0) begin
            v1 = 1; a1 = hist[bi];
            foreach (hist[i]) if (i != bi && (!v2 || hist[i] > a2)) begin
                v2 = 1; a2 = hist[i];
            end
        end
    endtask

    task automatic check_outputs(input string req, input logic exp_done);
        logic v1, v2;
        int a1, a2;
        expected(v1, a1, v2, a2);
        checks++;
        if (first_vld_o !== v1 || second_vld_o !== v2 || done_o !== exp_done ||
            (v1 && first_o !== DW'(a1)) || (v2 && second_o !== DW'(a2))) begin
            errors++;
            $display("FAIL %s: got vld=%b/%b val=%0d/%0d done=%b, expected vld=%b/%b val=%0d/%0d done=%b",
                     req, first_vld_o, second_vld_o, first_o, second_o, done_o,
                     v1, v2, a1, a2, exp_done);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic en, input int v, input string req);
        logic exp_done = 0;
        valid_i = en; sample_i = DW'(v);
        @(negedge clk);
        valid_i = 0;
        if (en && nacc < RUN) begin
            hist.push_back(v);
            nacc++;
            exp_done = (nacc == RUN);
        end
        check_outputs(req, exp_done);
    endtask

    task automatic do_clear(input logic with_valid, input int v, input string req);
        clear_i = 1; valid_i = with_valid; sample_i = DW'(v);
        @(negedge clk);
        clear_i = 0; valid_i = 0;
        hist.delete(); nacc = 0;
        check_outputs(req, 1'b0);
    endtask

    task automatic t_reset();
        check_outputs("R1 reset state", 1'b0);
        step(0, 0, "R1 idle after reset");
    endtask

    task automatic t_ascending();
        do_clear(0, 0, "R9 clear");
        for (int i = 1; i <= RUN; i++) step(1, i * 10, "R2 rising stream");
    endtask

    task automatic t_max_first();
        do_clear(0, 0, "R9 clear");
        step(1, 200, "R5 leader first");
        step(1, 3, "R3 second fill");
        step(1, 7, "R3 second replace");
        step(1, 5, "R4 below both");
        step(1, 150, "R5 second replace");
        step(1, 149, "R4 below second");
        step(1, 150, "R4 equal second");
        step(1, 1, "R4 small");
        step(1, 199, "R5 late second");
        step(1, 0, "R7 last sample");
    endtask

    task automatic t_ties();
        do_clear(0, 0, "R9 clear");
        step(1, 50, "R2 first value");
        step(1, 50, "R2 repeated max");
        step(1, 20, "R4 below");
        step(1, 80, "R2 new max demotes");
        step(1, 80, "R2 repeated max again");
    endtask

    task automatic t_zeros();
        do_clear(0, 0, "R9 clear");
        for (int i = 0; i < RUN; i++) step(1, 0, "R6 zero data");
    endtask

    task automatic t_gaps_and_overrun();
        do_clear(0, 0, "R9 clear");
        for (int i = 0; i < RUN; i++) begin
            step(1, (i * 37) % 256, "R10 sparse stream");
            step(0, 255, "R10 invalid cycle");
        end
        step(1, 255, "R8 ignored after run");
        step(1, 254, "R8 ignored after run");
        step(0, 0, "R8 hold");
    endtask

    task automatic t_clear_priority();
        do_clear(0, 0, "R9 clear");
        step(1, 12, "R2 one sample");
        do_clear(1, 255, "R9 clear beats valid");
        step(0, 0, "R9 still empty");
    endtask

    task automatic t_restart();
        do_clear(0, 0, "R9 clear");
        for (int i = 0; i < 4; i++) step(1, 90 + i, "R11 partial run");
        do_clear(0, 0, "R11 mid-run clear");
        for (int i = 0; i < RUN; i++) step(1, (i * 53 + 7) % 256, "R11 full run after clear");
        step(1, 3, "R8 ignored after run");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outputs("R1 during reset", 1'b0);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ascending();
        t_max_first();
        t_ties();
        t_zeros();
        t_gaps_and_overrun();
        t_clear_priority();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule